// File: doc/BRIEF.md
# SPI Link CRC Engine

This block keeps two running CRC registers beside an SPI serializer. One covers the outgoing bit stream and the other covers the incoming one. On every shift strobe the serializer hands it the bit it sent and the bit it received, and each enabled register advances by one bit, most significant bit first. The generator polynomial can be written by software, and the CRC can be 8 or 16 bits wide. In 8-bit mode only the low byte of the polynomial and of each register takes part.

At the end of a data word, software can arm a one-shot "send CRC next" command. When the serializer then reports that the word has ended, the engine freezes both registers and enters a CRC frame. For as many shifts as the CRC is wide, it presents the frozen transmit CRC on `crc_bit_o`, most significant bit first. While it does so it collects the bits arriving from the far end. On the cycle after the last of those bits it compares them with the frozen receive CRC. It raises a sticky error flag on a mismatch and drops the command bit on its own.

A small word-wide register port gives access to control, the polynomial and both CRC values. The serializer signals `busy_i` during a transfer, and while it is high, writes to the polynomial and to the width setting are ignored.

Top module: `spi_crc_unit`

## Requirements
- R1: After reset the polynomial register (address 1) reads 0x0007, the control register (address 0) reads 0, and both CRC registers (address 2 transmit, address 3 receive) read 0.
- R2: In 16-bit mode, with enable set, each shift strobe updates a register as crc = (crc << 1) XOR (poly if (crc[15] XOR bit) else 0), truncated to 16 bits.
- R3: In 8-bit mode (control bit 1 = 0) the update uses crc[7] as feedback and only poly[7:0], and the upper 8 bits of both CRC registers read 0.
- R4: With control bit 0 (enable) clear, shift strobes leave both registers unchanged. A write that takes enable from 0 to 1 clears both registers to 0 in that same clock edge.
- R5: When control bit 2 (send CRC next) is set and `word_end_i` pulses, `crc_phase_o` goes high. For the next L shift strobes (L = 8 or 16), `crc_bit_o` carries the transmit CRC MSB first, and neither CRC register changes.
- R6: The received CRC frame is compared with the frozen receive CRC in the cycle after its last bit. On a match the error flag stays 0, and in that cycle control bit 2 clears on its own.
- R7: On a mismatch the error flag (control bit 3, also `crc_err_o`) is set. It stays set when software writes 1 to that bit, and it clears only when software writes the control register with bit 3 = 0.
- R8: While `busy_i` is high, writes to the polynomial register and to the width bit (control bit 1) are ignored.
- R9: The transmit and receive registers track their own streams and can each be read back at their own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 polynomial, 2 transmit CRC, 3 receive CRC |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i, combinational |
| busy_i | input | 1 | Transfer in progress |
| shift_i | input | 1 | One bit shifted in each direction this cycle |
| tx_bit_i | input | 1 | Transmitted data bit |
| rx_bit_i | input | 1 | Received data bit |
| word_end_i | input | 1 | Current data word finished |
| crc_phase_o | output | 1 | CRC frame in progress |
| crc_bit_o | output | 1 | Transmit CRC bit to send during the CRC frame |
| crc_err_o | output | 1 | Sticky CRC mismatch flag |

## Verification
The bench sweeps several polynomials in both widths and compares each register against an arithmetic model. A design that used bit 15 as feedback in 8-bit mode, or leaked the upper polynomial byte, would miss the narrow results. Each sweep runs CRC frames that end with both a matching and a corrupted far-end CRC. These catch an off-by-one frame length, a compare that looks at the wrong bits, a command bit that never clears, and registers that keep shifting during the frame. The sweep also covers rising enable, disabled shifting, writes to the error bit with 1 and with 0, and polynomial and width writes during `busy_i`. These expose a flag that is not sticky, a missing clear, or configuration that changes while a transfer is running.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;
  localparam int unsigned CRC_W    = 16;
  localparam int unsigned NARROW_W = 8;
  localparam int unsigned POLY_RST = 7;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_POLY  = 2'd1,
    ADDR_TXCRC = 2'd2,
    ADDR_RXCRC = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_WIDE = 1;
  localparam int unsigned CTRL_NEXT = 2;
  localparam int unsigned CTRL_ERR  = 3;

  typedef struct packed {
    logic err;
    logic next;
    logic wide;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/spi_crc_lfsr.sv
module spi_crc_lfsr #(
  parameter int unsigned W  = spi_crc_pkg::CRC_W,
  parameter int unsigned NW = spi_crc_pkg::NARROW_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         step_i,
  input  logic         bit_i,
  input  logic         wide_i,
  input  logic [W-1:0] poly_i,
  output logic [W-1:0] crc_o
);
  localparam logic [W-1:0] NMASK = {{(W-NW){1'b0}}, {NW{1'b1}}};

  logic [W-1:0] crc_q, crc_d, mask;
  logic         fb;

  assign mask = wide_i ? '1 : NMASK;

  always_comb begin
    fb    = (wide_i ? crc_q[W-1] : crc_q[NW-1]) ^ bit_i;
    crc_d = ({crc_q[W-2:0], 1'b0} ^ (fb ? poly_i : '0)) & mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clear_i) crc_q <= '0;
    else if (step_i)  crc_q <= crc_d;
  end

  assign crc_o = crc_q & mask;
endmodule

// File: rtl/spi_crc_frame.sv
module spi_crc_frame #(
  parameter int unsigned W  = spi_crc_pkg::CRC_W,
  parameter int unsigned NW = spi_crc_pkg::NARROW_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         next_i,
  input  logic         wide_i,
  input  logic         word_end_i,
  input  logic         shift_i,
  input  logic         rx_bit_i,
  input  logic [W-1:0] tx_crc_i,
  input  logic [W-1:0] rx_crc_i,
  output logic         phase_o,
  output logic         bit_o,
  output logic         done_o,
  output logic         mismatch_o
);
  localparam int unsigned  CNT_W  = $clog2(W);
  localparam logic [CNT_W-1:0] LAST_W = CNT_W'(W - 1);
  localparam logic [CNT_W-1:0] LAST_N = CNT_W'(NW - 1);
  localparam logic [W-1:0] NMASK  = {{(W-NW){1'b0}}, {NW{1'b1}}};

  logic             phase_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     tx_sh_q, snap_q, cap_q, mask;
  logic             last;

  assign mask = wide_i ? '1 : NMASK;
  assign last = (cnt_q == (wide_i ? LAST_W : LAST_N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      tx_sh_q <= '0;
      snap_q  <= '0;
      cap_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!phase_q) begin
        if (en_i && next_i && word_end_i && !done_q) begin
          phase_q <= 1'b1;
          cnt_q   <= '0;
          tx_sh_q <= tx_crc_i;
          snap_q  <= rx_crc_i;
          cap_q   <= '0;
        end
      end else if (shift_i) begin
        tx_sh_q <= {tx_sh_q[W-2:0], 1'b0};
        cap_q   <= {cap_q[W-2:0], rx_bit_i};
        cnt_q   <= cnt_q + 1'b1;
        if (last) begin
          phase_q <= 1'b0;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign phase_o    = phase_q;
  assign bit_o      = phase_q & (wide_i ? tx_sh_q[W-1] : tx_sh_q[NW-1]);
  assign done_o     = done_q;
  assign mismatch_o = done_q && ((cap_q & mask) != (snap_q & mask));
endmodule

// File: rtl/spi_crc_regs.sv
module spi_crc_regs
  import spi_crc_pkg::*;
#(
  parameter int unsigned W = CRC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         reg_we_i,
  input  logic [1:0]   reg_addr_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  input  logic         busy_i,
  input  logic         done_i,
  input  logic         err_set_i,
  input  logic [W-1:0] tx_crc_i,
  input  logic [W-1:0] rx_crc_i,
  output ctrl_t        ctrl_o,
  output logic [W-1:0] poly_o,
  output logic         en_rise_o
);
  ctrl_t        ctrl_q;
  logic [W-1:0] poly_q;
  logic         wr_ctrl, wr_poly;

  assign wr_ctrl   = reg_we_i && (reg_addr_e'(reg_addr_i) == ADDR_CTRL);
  assign wr_poly   = reg_we_i && (reg_addr_e'(reg_addr_i) == ADDR_POLY);
  assign en_rise_o = wr_ctrl && reg_wdata_i[CTRL_EN] && !ctrl_q.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      poly_q <= W'(POLY_RST);
    end else begin
      if (wr_poly && !busy_i) poly_q <= reg_wdata_i;
      if (wr_ctrl) begin
        ctrl_q.en   <= reg_wdata_i[CTRL_EN];
        ctrl_q.next <= reg_wdata_i[CTRL_NEXT];
        if (!busy_i)               ctrl_q.wide <= reg_wdata_i[CTRL_WIDE];
        if (!reg_wdata_i[CTRL_ERR]) ctrl_q.err <= 1'b0;
      end
      if (done_i)    ctrl_q.next <= 1'b0;
      if (err_set_i) ctrl_q.err  <= 1'b1;
    end
  end

  always_comb begin
    unique case (reg_addr_e'(reg_addr_i))
      ADDR_CTRL:  reg_rdata_o = W'(ctrl_q);
      ADDR_POLY:  reg_rdata_o = poly_q;
      ADDR_TXCRC: reg_rdata_o = tx_crc_i;
      default:    reg_rdata_o = rx_crc_i;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign poly_o = poly_q;
endmodule

// File: rtl/spi_crc_unit.sv
module spi_crc_unit
  import spi_crc_pkg::*;
#(
  parameter int unsigned W  = CRC_W,
  parameter int unsigned NW = NARROW_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         reg_we_i,
  input  logic [1:0]   reg_addr_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  input  logic         busy_i,
  input  logic         shift_i,
  input  logic         tx_bit_i,
  input  logic         rx_bit_i,
  input  logic         word_end_i,
  output logic         crc_phase_o,
  output logic         crc_bit_o,
  output logic         crc_err_o
);
  localparam int unsigned NSTREAM = 2;

  ctrl_t        ctrl;
  logic [W-1:0] poly, tx_crc, rx_crc;
  logic         en_rise, crc_phase, frame_done, mismatch, step;
  logic [NSTREAM-1:0] stream_bit;
  logic [W-1:0] stream_crc [NSTREAM];

  assign step       = ctrl.en && shift_i && !crc_phase;
  assign stream_bit = {rx_bit_i, tx_bit_i};

  for (genvar g = 0; g < NSTREAM; g++) begin : g_stream
    spi_crc_lfsr #(.W(W), .NW(NW)) u_lfsr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (en_rise),
      .step_i  (step),
      .bit_i   (stream_bit[g]),
      .wide_i  (ctrl.wide),
      .poly_i  (poly),
      .crc_o   (stream_crc[g])
    );
  end

  assign tx_crc = stream_crc[0];
  assign rx_crc = stream_crc[1];

  spi_crc_frame #(.W(W), .NW(NW)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl.en),
    .next_i     (ctrl.next),
    .wide_i     (ctrl.wide),
    .word_end_i (word_end_i),
    .shift_i    (shift_i),
    .rx_bit_i   (rx_bit_i),
    .tx_crc_i   (tx_crc),
    .rx_crc_i   (rx_crc),
    .phase_o    (crc_phase),
    .bit_o      (crc_bit_o),
    .done_o     (frame_done),
    .mismatch_o (mismatch)
  );

  spi_crc_regs #(.W(W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .busy_i      (busy_i),
    .done_i      (frame_done),
    .err_set_i   (mismatch),
    .tx_crc_i    (tx_crc),
    .rx_crc_i    (rx_crc),
    .ctrl_o      (ctrl),
    .poly_o      (poly),
    .en_rise_o   (en_rise)
  );

  assign crc_phase_o = crc_phase;
  assign crc_err_o   = ctrl.err;
endmodule

// File: rtl/spi_crc_unit_chk.sv
module spi_crc_unit_chk #(
  parameter int unsigned W = spi_crc_pkg::CRC_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         busy_i,
  input logic         reg_we_i,
  input logic [1:0]   reg_addr_i,
  input logic [W-1:0] reg_wdata_i,
  input logic         en_q,
  input logic         wide_q,
  input logic         next_q,
  input logic         err_q,
  input logic [W-1:0] poly_q,
  input logic         phase,
  input logic         done,
  input logic [W-1:0] tx_crc,
  input logic [W-1:0] rx_crc
);
  logic ctrl_wr;
  assign ctrl_wr = reg_we_i && reg_addr_i == 2'd0;

  a_r4_clear_on_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> (tx_crc == '0 && rx_crc == '0));

  a_r5_frozen_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase |=> ($stable(tx_crc) && $stable(rx_crc)));

  a_r6_next_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !next_q);

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !(ctrl_wr && !reg_wdata_i[3])) |=> err_q);

  a_r8_poly_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && reg_we_i && reg_addr_i == 2'd1) |=> $stable(poly_q));

  a_r8_wide_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && ctrl_wr) |=> $stable(wide_q));
endmodule

bind spi_crc_unit spi_crc_unit_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_i      (busy_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .en_q        (ctrl.en),
  .wide_q      (ctrl.wide),
  .next_q      (ctrl.next),
  .err_q       (ctrl.err),
  .poly_q      (poly),
  .phase       (crc_phase),
  .done        (frame_done),
  .tx_crc      (tx_crc),
  .rx_crc      (rx_crc)
);

// File: tb/spi_crc_unit_tb.sv
`timescale 1ns/1ps
module spi_crc_unit_tb;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0, reg_rdata_o;
  logic        busy_i = 1'b0, shift_i = 1'b0, tx_bit_i = 1'b0, rx_bit_i = 1'b0, word_end_i = 1'b0;
  logic        crc_phase_o, crc_bit_o, crc_err_o;

  int errors = 0, checks = 0;
  bit done_flag = 1'b0;

  always #5 clk_i = ~clk_i;

  spi_crc_unit u_dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_step(input logic [15:0] c, input logic b,
                                           input logic [15:0] p, input logic wide);
    logic fb;
    logic [15:0] n;
    fb = (wide ? c[15] : c[7]) ^ b;
    n  = {c[14:0], 1'b0} ^ (fb ? p : 16'h0);
    return wide ? n : {8'h00, n[7:0]};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic shift1(input logic t, input logic r);
    shift_i = 1'b1; tx_bit_i = t; rx_bit_i = r;
    @(negedge clk_i);
    shift_i = 1'b0;
  endtask

  logic [15:0] v;

  initial begin
    logic [15:0] polys [5];
    logic [15:0] pat;
    polys[0] = 16'h0007; polys[1] = 16'h8005; polys[2] = 16'h1021;
    polys[3] = 16'h00D5; polys[4] = 16'h3D65;
    pat = 16'hACE1;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(2'd1, v); chk("R1 poly reset", v, 16'h0007);
    rd(2'd0, v); chk("R1 ctrl reset", v, 16'h0000);
    rd(2'd2, v); chk("R1 txcrc reset", v, 16'h0000);
    rd(2'd3, v); chk("R1 rxcrc reset", v, 16'h0000);

    for (int pi = 0; pi < 5; pi++) begin
      for (int wi = 0; wi < 2; wi++) begin
        for (int bad = 0; bad < 2; bad++) begin
          logic [15:0] p, etx, erx, ctl;
          logic w;
          int L;
          p = polys[pi]; w = wi[0]; L = w ? 16 : 8;
          etx = '0; erx = '0;
          ctl = {13'd0, 1'b0, w, 1'b1};
          wr(2'd0, 16'h0000);
          wr(2'd1, p);
          // junk while disabled must not move the registers
          for (int k = 0; k < 3; k++) shift1(1'b1, 1'b1);
          wr(2'd0, {14'd0, w, 1'b0});
          wr(2'd0, ctl);
          rd(2'd2, v); chk("R4 clear tx on enable", v, 16'h0000);
          rd(2'd3, v); chk("R4 clear rx on enable", v, 16'h0000);
          busy_i = 1'b1;
          for (int k = 0; k < 24; k++) begin
            logic t, r;
            pat = {pat[14:0], pat[15] ^ pat[13] ^ pat[12] ^ pat[10]};
            t = pat[0]; r = pat[5] ^ pat[9];
            etx = ref_step(etx, t, p, w);
            erx = ref_step(erx, r, p, w);
            shift1(t, r);
          end
          rd(2'd2, v); chk(w ? "R2 tx crc 16" : "R3 tx crc 8", v, etx);
          rd(2'd3, v); chk("R9 rx crc independent", v, erx);
          wr(2'd1, 16'h5A5A);
          rd(2'd1, v); chk("R8 poly write ignored while busy", v, p);
          wr(2'd0, {ctl[15:2], ~w, 1'b1});
          rd(2'd0, v); chk("R8 width write ignored while busy", {15'd0, v[1]}, {15'd0, w});
          wr(2'd0, ctl | 16'h0004);
          word_end_i = 1'b1;
          @(negedge clk_i);
          word_end_i = 1'b0;
          chk("R5 phase raised", {15'd0, crc_phase_o}, 16'h0001);
          for (int k = L - 1; k >= 0; k--) begin
            logic r;
            chk("R5 crc bit out", {15'd0, crc_bit_o}, {15'd0, etx[k]});
            r = erx[k] ^ ((bad == 1 && k == 0) ? 1'b1 : 1'b0);
            shift1(~etx[k], r);
          end
          rd(2'd2, v); chk("R5 tx frozen in frame", v, etx);
          rd(2'd3, v); chk("R5 rx frozen in frame", v, erx);
          @(negedge clk_i);
          busy_i = 1'b0;
          chk("R5 phase dropped", {15'd0, crc_phase_o}, 16'h0000);
          rd(2'd0, v);
          chk("R6 next self-clears", {15'd0, v[2]}, 16'h0000);
          chk(bad ? "R7 mismatch sets error" : "R6 match leaves error clear",
              {15'd0, crc_err_o}, {15'd0, bad[0]});
          if (bad == 1) begin
            wr(2'd0, ctl | 16'h0008);
            chk("R7 write 1 keeps error", {15'd0, crc_err_o}, 16'h0001);
            wr(2'd0, ctl);
            chk("R7 write 0 clears error", {15'd0, crc_err_o}, 16'h0000);
          end
          wr(2'd0, {14'd0, w, 1'b0});
          for (int k = 0; k < 5; k++) shift1(1'b1, 1'b0);
          rd(2'd2, v); chk("R4 disabled tx hold", v, etx);
          rd(2'd3, v); chk("R4 disabled rx hold", v, erx);
        end
      end
    end
    done_flag = 1'b1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (150000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule